// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a clocked serial port acting as master. It generates the shift clock itself, drives it on `sck_out`, and samples the serial data line `data_in` on each falling edge of that clock. Words are 8 bits wide, or 9 bits when the nine-bit option is on. They arrive least significant bit first. The shift clock rate comes from a divider value, which can be used at its full 16-bit width or cut down to its low byte.

Two reception modes are offered. A one-cycle pulse on `single_req` arms a single-word reception. That arm clears itself when the word is done. Holding `cont_en` high receives words back to back. When both modes are active, the continuous mode governs. The clock runs only while a reception is active and otherwise rests at the level chosen by `clk_pol`. A completed word goes to a holding register and raises a completion flag, which can also drive an interrupt. A read strobe clears the flag. If a word completes while the flag is still set, that word is dropped and an overrun status is raised.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_bit8`, `done_flag`, `overrun`, `single_busy` and `irq` are 0. While neither `single_busy` nor `cont_en` is 1, `sck_out` rests at `clk_pol` from the next cycle on (0 = idle low, 1 = idle high).
- R2: While a reception is active, `sck_out` toggles once every D+1 clock cycles. D is `div_val` when `div_wide` = 1, and `div_val[7:0]` when `div_wide` = 0, in which case the upper byte has no effect.
- R3: A pulse on `single_req` sets `single_busy`. After exactly one word, `single_busy` returns to 0 and the shift clock stops.
- R4: With `cont_en` = 1, words are received back to back. When both `single_busy` and `cont_en` are 0, a partly received word is abandoned, and the next reception starts again at bit 0.
- R5: `data_in` is sampled at the clock edge on which `sck_out` goes from 1 to 0. The k-th such edge of a word carries bit k, least significant first.
- R6: With `nine_bit_en` = 1, a word takes nine falling edges, bits 7..0 go to `rx_data` and bit 8 goes to `rx_bit8`. With `nine_bit_en` = 0, a word takes eight falling edges and `rx_bit8` is loaded with 0.
- R7: When a single reception and `cont_en` are active together, reception continues after the first word. `single_busy` still drops when that first word completes.
- R8: On word completion, `rx_data` is loaded and `done_flag` is set. `irq` equals `done_flag` while `irq_en` = 1 and is 0 otherwise. A `rd_pulse` clears `done_flag`, but a completion in the same cycle wins.
- R9: If a word completes while `done_flag` = 1 and no `rd_pulse` arrives in that cycle, `overrun` is set and `rx_data` is left unchanged. `overrun` clears in the cycle after `cont_en` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_val | input | 16 | Clock divider value D |
| div_wide | input | 1 | 1 uses all 16 divider bits, 0 uses the low byte only |
| clk_pol | input | 1 | Idle level of the shift clock |
| nine_bit_en | input | 1 | Nine-bit word enable |
| single_req | input | 1 | One-cycle pulse that arms a single-word reception |
| cont_en | input | 1 | Continuous reception enable |
| rd_pulse | input | 1 | Read strobe for the received word; clears the completion flag |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| data_in | input | 1 | Serial data line |
| sck_out | output | 1 | Shift clock driven by the master |
| rx_data | output | 8 | Received word, bits 7..0 |
| rx_bit8 | output | 1 | Ninth received bit |
| done_flag | output | 1 | Receive-complete flag |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun status |
| single_busy | output | 1 | Single-word reception armed |

## Verification
A wrong bit counter or a wrong shift register position shows up as a wrong `rx_data` or `rx_bit8` at the end of that same word. A wrong divider count moves the next `sck_out` toggle within one half period. A stuck arm or a stuck run state keeps `sck_out` toggling after a single word, or leaves it off its idle level, and this is visible within one divider period. Flag and overrun errors appear on the cycle after the completing edge. The bench therefore compares every output against its own model on every clock, and also makes directed checks of words, periods and overrun at the points where they settle.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  parameter int SRX_DATA_W   = 8;
  parameter int SRX_DIV_W    = 16;
  parameter int SRX_NARROW_W = 8;

  // Control and status state held by the receive controller
  typedef struct packed {
    logic flag;    // word waiting to be read
    logic ovr;     // word lost while flag was set
    logic single;  // single-word reception armed
    logic cont_q;  // delayed continuous enable, for edge detect
  } rx_state_t;

endpackage

// File: rtl/srx_baud_gen.sv
module srx_baud_gen #(
  parameter int DIV_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_wide,
  output logic             tick
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  generate
    if (NARROW_W < DIV_W) begin : g_sel
      assign div_eff = div_wide ? div_val
                                : {{(DIV_W-NARROW_W){1'b0}}, div_val[NARROW_W-1:0]};
    end else begin : g_full
      assign div_eff = div_val;
    end
  endgenerate

  assign tick = run && (cnt_q == div_eff);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          clk_pol,
  input  logic          nine_bit_en,
  input  logic          data_in,
  output logic          sck,
  output logic          word_done,
  output logic [DATA_W:0] word
);

  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              sck_q, sck_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  last_bit;

  assign last_bit = nine_bit_en ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  always_comb begin
    sck_d     = sck_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    word_done = 1'b0;
    if (!run) begin
      sck_d = clk_pol;
      bit_d = '0;
    end else if (tick) begin
      sck_d = ~sck_q;
      if (sck_q) begin
        for (int i = 0; i < WORD_W; i++) begin
          if (bit_q == CNT_W'(i)) begin
            sh_d[i] = data_in;
          end
        end
        if (bit_q == last_bit) begin
          word_done = 1'b1;
          bit_d     = '0;
        end else begin
          bit_d = bit_q + CNT_W'(1);
        end
      end
    end
  end

  assign sck  = sck_q;
  assign word = sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      sck_q <= sck_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

endmodule

// File: rtl/srx_rx_ctrl.sv
module srx_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_req,
  input  logic              cont_en,
  input  logic              rd_pulse,
  input  logic              nine_bit_en,
  input  logic              word_done,
  input  logic [DATA_W:0]   word,
  output logic              run,
  output logic              single_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              done_flag,
  output logic              overrun
);

  rx_state_t         st_q, st_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b8_q, b8_d;
  logic              load_en;

  // Continuous enable takes precedence; either one keeps the clock running
  assign run = st_q.single | cont_en;

  assign load_en = word_done && !(st_q.flag && !rd_pulse);

  always_comb begin
    st_d        = st_q;
    data_d      = data_q;
    b8_d        = b8_q;
    st_d.cont_q = cont_en;
    if (st_q.cont_q && !cont_en) begin
      st_d.ovr = 1'b0;
    end
    if (word_done) begin
      if (!load_en) begin
        st_d.ovr = 1'b1;
      end else begin
        st_d.flag = 1'b1;
      end
      st_d.single = 1'b0;
    end else if (rd_pulse) begin
      st_d.flag = 1'b0;
    end
    if (load_en) begin
      data_d = word[DATA_W-1:0];
      b8_d   = nine_bit_en & word[DATA_W];
    end
    if (single_req) begin
      st_d.single = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      data_q <= '0;
      b8_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
      b8_q   <= b8_d;
    end
  end

  assign single_busy = st_q.single;
  assign rx_data     = data_q;
  assign rx_bit8     = b8_q;
  assign done_flag   = st_q.flag;
  assign overrun     = st_q.ovr;

endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int DATA_W   = SRX_DATA_W,
  parameter int DIV_W    = SRX_DIV_W,
  parameter int NARROW_W = SRX_NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              div_wide,
  input  logic              clk_pol,
  input  logic              nine_bit_en,
  input  logic              single_req,
  input  logic              cont_en,
  input  logic              rd_pulse,
  input  logic              irq_en,
  input  logic              data_in,
  output logic              sck_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              done_flag,
  output logic              irq,
  output logic              overrun,
  output logic              single_busy
);

  logic            rs_meta_q, rs_sync_q;
  logic            rst_int_n;
  logic            run;
  logic            tick;
  logic            word_done;
  logic [DATA_W:0] word;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end
  assign rst_int_n = rs_sync_q;

  srx_baud_gen #(
    .DIV_W    (DIV_W),
    .NARROW_W (NARROW_W)
  ) u_baud (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .div_val  (div_val),
    .div_wide (div_wide),
    .tick     (tick)
  );

  srx_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (run),
    .tick        (tick),
    .clk_pol     (clk_pol),
    .nine_bit_en (nine_bit_en),
    .data_in     (data_in),
    .sck         (sck_out),
    .word_done   (word_done),
    .word        (word)
  );

  srx_rx_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .single_req  (single_req),
    .cont_en     (cont_en),
    .rd_pulse    (rd_pulse),
    .nine_bit_en (nine_bit_en),
    .word_done   (word_done),
    .word        (word),
    .run         (run),
    .single_busy (single_busy),
    .rx_data     (rx_data),
    .rx_bit8     (rx_bit8),
    .done_flag   (done_flag),
    .overrun     (overrun)
  );

  assign irq = done_flag & irq_en;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cont_en,
  input logic              clk_pol,
  input logic              single_busy,
  input logic              sck_out,
  input logic              done_flag,
  input logic              overrun,
  input logic [DATA_W-1:0] rx_data,
  input logic              word_done
);

  // R1: idle clock rests at the polarity level
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_busy && !cont_en) |=> (sck_out == $past(clk_pol)));

  // R3: the single arm is dropped only by a completed word
  p_single_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_busy) |-> $past(word_done));

  // R5: a word completes on a falling shift clock edge
  p_fall_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !sck_out);

  // R8: the flag rises only on a completed word
  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(word_done));

  // R9: overrun keeps the held word and needs a pending flag
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(done_flag) && $stable(rx_data)));

endmodule

bind sync_rx_master srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cont_en     (cont_en),
  .clk_pol     (clk_pol),
  .single_busy (single_busy),
  .sck_out     (sck_out),
  .done_flag   (done_flag),
  .overrun     (overrun),
  .rx_data     (rx_data),
  .word_done   (word_done)
);

// File: tb/sync_rx_master_tb.sv
`timescale 1ns/1ps
module sync_rx_master_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] div_val;
  logic        div_wide, clk_pol, nine_bit_en, single_req, cont_en, rd_pulse, irq_en, data_in;
  logic        sck_out;
  logic [7:0]  rx_data;
  logic        rx_bit8, done_flag, irq, overrun, single_busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  sync_rx_master u_dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wide(div_wide),
    .clk_pol(clk_pol), .nine_bit_en(nine_bit_en), .single_req(single_req),
    .cont_en(cont_en), .rd_pulse(rd_pulse), .irq_en(irq_en), .data_in(data_in),
    .sck_out(sck_out), .rx_data(rx_data), .rx_bit8(rx_bit8), .done_flag(done_flag),
    .irq(irq), .overrun(overrun), .single_busy(single_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [8:0] pat(input int n);
    return 9'(n * 151 + 90);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_rel, m_cnt, m_bit, m_wcount, dv;
  logic       m_sck, m_flag, m_ovr, m_single, m_cont_q, m_b8, act, dn;
  logic [8:0] m_shift;
  logic [7:0] m_data;

  task automatic m_reset();
    m_cnt = 0; m_bit = 0; m_sck = 1'b0; m_flag = 1'b0; m_ovr = 1'b0;
    m_single = 1'b0; m_cont_q = 1'b0; m_b8 = 1'b0; m_shift = '0; m_data = '0;
  endtask

  initial begin m_rel = 0; m_wcount = 0; m_reset(); end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_reset();
    end else if (m_rel < 2) begin
      m_rel++; m_reset();
    end else begin
      act = m_single || cont_en;
      dv  = div_wide ? int'(div_val) : int'(div_val[7:0]);
      dn  = 1'b0;
      if (!act) begin
        m_cnt = 0; m_sck = clk_pol; m_bit = 0;
      end else if (m_cnt == dv) begin
        m_cnt = 0;
        if (m_sck) begin
          m_shift[m_bit] = data_in;
          if (m_bit == (nine_bit_en ? 8 : 7)) begin dn = 1'b1; m_bit = 0; end
          else m_bit++;
        end
        m_sck = !m_sck;
      end else begin
        m_cnt++;
      end
      if (m_cont_q && !cont_en) m_ovr = 1'b0;
      if (dn) begin
        if (m_flag && !rd_pulse) m_ovr = 1'b1;
        else begin
          m_data = m_shift[7:0];
          m_b8   = nine_bit_en ? m_shift[8] : 1'b0;
          m_flag = 1'b1;
        end
        m_single = 1'b0;
        m_wcount++;
      end else if (rd_pulse) begin
        m_flag = 1'b0;
      end
      if (single_req) m_single = 1'b1;
      m_cont_q = cont_en;
    end
  end

  // serial source: the bit the model expects next
  always @(negedge clk) begin
    logic [8:0] w;
    w = pat(m_wcount);
    data_in = w[m_bit];
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if ((sck_out !== m_sck) || (rx_data !== m_data) || (rx_bit8 !== m_b8) ||
          (done_flag !== m_flag) || (overrun !== m_ovr) || (single_busy !== m_single) ||
          (irq !== (m_flag & irq_en))) begin
        fails++;
        if (sck_out !== m_sck) $display("FAIL R2 sck actual=%0h expected=%0h", sck_out, m_sck);
        if (rx_data !== m_data) $display("FAIL R5 data actual=%0h expected=%0h", rx_data, m_data);
        if (rx_bit8 !== m_b8) $display("FAIL R6 bit8 actual=%0h expected=%0h", rx_bit8, m_b8);
        if (done_flag !== m_flag) $display("FAIL R8 flag actual=%0h expected=%0h", done_flag, m_flag);
        if (irq !== (m_flag & irq_en)) $display("FAIL R8 irq actual=%0h expected=%0h", irq, m_flag & irq_en);
        if (overrun !== m_ovr) $display("FAIL R9 overrun actual=%0h expected=%0h", overrun, m_ovr);
        if (single_busy !== m_single) $display("FAIL R3 busy actual=%0h expected=%0h", single_busy, m_single);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_flag(input string tag);
    int t;
    t = 0;
    while (!done_flag && t < 20000) begin @(posedge clk); #1; t++; end
    chk(done_flag == 1'b1, tag, done_flag, 1);
  endtask

  task automatic pulse_single();
    @(negedge clk); single_req = 1'b1;
    @(negedge clk); single_req = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
  endtask

  task automatic half_period(input int exp, input string tag);
    logic s0;
    int   n, t;
    t = 0;
    s0 = sck_out;
    while (sck_out == s0 && t < 70000) begin @(posedge clk); #1; t++; end
    s0 = sck_out; n = 0;
    while (sck_out == s0 && n < 70000) begin @(posedge clk); #1; n++; end
    chk(n == exp, tag, n, exp);
  endtask

  int idx;
  int falls;

  initial begin
    rst_n = 1'b0; div_val = 16'd3; div_wide = 1'b0; clk_pol = 1'b0; nine_bit_en = 1'b0;
    single_req = 1'b0; cont_en = 1'b0; rd_pulse = 1'b0; irq_en = 1'b0;
    tick_n(3);
    @(negedge clk); rst_n = 1'b1;
    tick_n(4);
    // R1 reset state and idle level
    chk(rx_data == 8'h00, "R1 reset data", rx_data, 0);
    chk({done_flag, overrun, single_busy, irq, rx_bit8} == 5'b0, "R1 reset status",
        {done_flag, overrun, single_busy, irq, rx_bit8}, 0);
    chk(sck_out == 1'b0, "R1 idle low", sck_out, 0);
    @(negedge clk); clk_pol = 1'b1;
    tick_n(2);
    chk(sck_out == 1'b1, "R1 idle high", sck_out, 1);
    @(negedge clk); clk_pol = 1'b0;
    tick_n(2);

    // R3 R5 single 8-bit word, idle low, narrow divider 3
    idx = m_wcount;
    pulse_single();
    half_period(4, "R2 half period narrow");
    wait_flag("R3 single done");
    chk(rx_data == pat(idx)[7:0], "R5 single word", rx_data, pat(idx)[7:0]);
    chk(rx_bit8 == 1'b0, "R6 bit8 zero in 8-bit mode", rx_bit8, 0);
    tick_n(20);
    chk(single_busy == 1'b0, "R3 busy dropped", single_busy, 0);
    chk(sck_out == 1'b0, "R3 clock stopped", sck_out, 0);
    do_read();
    tick_n(1);
    chk(done_flag == 1'b0, "R8 read clears flag", done_flag, 0);

    // R2 upper byte ignored when narrow
    @(negedge clk); div_val = 16'h0503;
    pulse_single();
    half_period(4, "R2 upper byte ignored");
    wait_flag("R3 narrow word");
    do_read();

    // R6 nine-bit word, idle high, wide divider
    @(negedge clk); div_val = 16'h0102; div_wide = 1'b1; clk_pol = 1'b1; nine_bit_en = 1'b1;
    tick_n(2);
    idx = m_wcount;
    pulse_single();
    half_period(259, "R2 half period wide");
    wait_flag("R6 nine-bit done");
    chk(rx_data == pat(idx)[7:0], "R6 nine-bit low byte", rx_data, pat(idx)[7:0]);
    chk(rx_bit8 == pat(idx)[8], "R6 ninth bit", rx_bit8, pat(idx)[8]);
    do_read();

    // R4 R8 continuous with interrupts
    @(negedge clk); div_val = 16'd2; div_wide = 1'b0; clk_pol = 1'b0; nine_bit_en = 1'b0; irq_en = 1'b1;
    idx = m_wcount;
    @(negedge clk); cont_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_flag("R4 continuous word");
      chk(irq == 1'b1, "R8 irq raised", irq, 1);
      chk(rx_data == pat(idx + k)[7:0], "R4 back-to-back data", rx_data, pat(idx + k)[7:0]);
      do_read();
    end
    @(negedge clk); cont_en = 1'b0;
    tick_n(4);
    if (done_flag) do_read();
    @(negedge clk); irq_en = 1'b0;
    tick_n(2);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);

    // R9 overrun
    idx = m_wcount;
    @(negedge clk); cont_en = 1'b1;
    wait_flag("R9 first word");
    begin
      int t;
      t = 0;
      while (!overrun && t < 5000) begin @(posedge clk); #1; t++; end
    end
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    chk(rx_data == pat(idx)[7:0], "R9 data kept", rx_data, pat(idx)[7:0]);
    @(negedge clk); cont_en = 1'b0;
    @(posedge clk); #1;
    chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
    do_read();

    // R7 precedence of continuous over single
    idx = m_wcount;
    @(negedge clk); single_req = 1'b1; cont_en = 1'b1;
    @(negedge clk); single_req = 1'b0;
    wait_flag("R7 first word");
    tick_n(1);
    chk(single_busy == 1'b0, "R7 single arm spent", single_busy, 0);
    do_read();
    wait_flag("R7 reception continues");
    chk(rx_data == pat(idx + 1)[7:0], "R7 second word", rx_data, pat(idx + 1)[7:0]);
    @(negedge clk); cont_en = 1'b0;
    tick_n(3);
    if (done_flag) do_read();

    // R4 abandon partial word
    @(negedge clk); cont_en = 1'b1;
    falls = 0;
    while (falls < 3) begin
      logic s;
      s = sck_out;
      @(posedge clk); #1;
      if (s && !sck_out) falls++;
    end
    @(negedge clk); cont_en = 1'b0;
    tick_n(2);
    chk(sck_out == 1'b0, "R4 clock stops on abandon", sck_out, 0);
    chk(done_flag == 1'b0, "R4 no word from abandon", done_flag, 0);
    idx = m_wcount;
    pulse_single();
    wait_flag("R4 restart word");
    chk(rx_data == pat(idx)[7:0], "R4 restart from bit 0", rx_data, pat(idx)[7:0]);
    do_read();
    tick_n(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule